// File: doc/BRIEF.md
# Single-Error-Correcting Byte Memory

This block is a small synchronous byte memory that protects every stored byte with four check bits. A write encodes the byte into a 12-bit Hamming codeword and stores it. A read decodes the addressed codeword, inverts any single flipped bit, and returns the repaired byte. A separate flag reports that a repair took place. The repair is applied only on the way out: the array keeps the damaged word until software writes that location again.

Two select inputs must both be active before anything happens. One is active low and the other is active high. A write strobe and a read gate then choose the operation. The byte-wide bidirectional data pin and the flag pin are modelled as a value plus a drive-enable each. A fault port XORs a 12-bit mask into one stored word, so that the correction path can be exercised.

All actions are taken at the rising clock edge. Read results, the flag and both drive-enables are registered, so they appear one cycle after the command that produced them.

Top module: `sec_byte_ram`

## Requirements
- R1: The part is selected only while `sel_a_n` is 0 and `sel_b` is 1. While it is deselected, no write takes place and both drive-enables are 0 in the following cycle.
- R2: A selected cycle with `wr_en_n` = 0 stores all 8 bits of `wdata` at `addr`, whatever the value of `out_en_n`.
- R3: A selected cycle with `out_en_n` = 0 and `wr_en_n` = 1 is a read. In the next cycle `rdata_drv` is 1 and `rdata` holds the corrected byte of that address.
- R4: After any cycle that is not a read (deselected, read gate high, or write), `rdata_drv` is 0 in the next cycle.
- R5: On a read, `fix_flag` is 0 when the stored word is intact. It is 1 when exactly one stored bit differs from the written codeword, and in that case `rdata` still equals the byte that was written.
- R6: `fix_flag_drv` equals `rdata_drv` in every cycle, so the flag is valid in the same cycle as the byte it describes.
- R7: A corrected word is not written back. Repeated reads of a damaged location keep reporting `fix_flag` = 1 until that location is written again.
- R8: A selected cycle with both `out_en_n` and `wr_en_n` at 1 drives nothing and changes no stored word.
- R9: Bit k of `flt_mask` (k = 0..11) flips codeword position k+1. Positions 1, 2, 4 and 8 hold the check bits and the other positions hold the data bits, in ascending order. A single flip at any of the 12 positions is corrected. Flipping the same bit twice restores the word, and the flag then reads 0.
- R10: While `rst_n` is 0 at a clock edge, both drive-enables go to 0 and every location is cleared to the all-zero codeword, which reads back as 0 with the flag at 0.
- R11: Injection takes effect at the clock edge. A read in the same cycle sees the word as it was before the edge. A write to the same address in the same cycle takes precedence, and the injection is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_a_n | input | 1 | Active-low select |
| sel_b | input | 1 | Active-high select |
| out_en_n | input | 1 | Active-low read gate |
| wr_en_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 8 | Byte to store |
| rdata | output | 8 | Corrected read byte |
| rdata_drv | output | 1 | Drive-enable of the data pin |
| fix_flag | output | 1 | Single-bit repair indication |
| fix_flag_drv | output | 1 | Drive-enable of the flag pin |
| flt_en | input | 1 | Fault-injection strobe |
| flt_addr | input | ADDR_W | Word to corrupt |
| flt_mask | input | 12 | Bits to flip in that codeword |

## Verification
The bench flips each of the twelve codeword positions in turn, including the four check-bit positions. A decoder with a mis-wired syndrome would return a corrupted byte, or raise the flag for a bit it never repaired. Every damaged word is read twice and then rewritten. A design that wrote the repair back would clear the flag on the second read, and one that did not store on rewrite would keep the flag raised. Writes made under each deselect condition, and the selected idle mode, must leave the stored byte unchanged. The bench also checks that the flag never stays driven after a write or an idle cycle. Injection that collides with a read or a write in the same cycle checks the edge ordering: a read that saw the flipped word would raise the flag early, and an injection that overrode the write would leave the new byte damaged.

// File: rtl/sec_ram_pkg.sv
// Shared constants and types of the single-error-correcting byte memory.
// Assumes a Hamming layout with check bits at power-of-two positions.
package sec_ram_pkg;
    localparam int DATA_W = 8;
    localparam int CHK_W  = 4;
    localparam int CW_W   = DATA_W + CHK_W;

    typedef logic [CW_W-1:0] codeword_t;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_WRITE = 2'd1,
        MODE_READ  = 2'd2,
        MODE_QUIET = 2'd3
    } mode_t;
endpackage

// File: rtl/sec_encoder.sv
// Builds a Hamming codeword from one data byte.
// Position p (1-based) maps to codeword bit p-1. Data fills the
// non-power-of-two positions in ascending order. Check bit c sits at
// position 2**c and gives even parity over all positions with bit c set.
module sec_encoder
    import sec_ram_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output codeword_t         cw_o
);
    // Place the data bits, then fill in each check bit.
    always_comb begin : build_cw
        int   j;
        logic par;
        cw_o = '0;
        j    = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw_o[p-1] = data_i[j];
                j++;
            end
        end
        for (int c = 0; c < CHK_W; c++) begin
            par = 1'b0;
            for (int p = 1; p <= CW_W; p++) begin
                if (p[c]) par = par ^ cw_o[p-1];
            end
            cw_o[(1 << c) - 1] = par;
        end
    end
endmodule

// File: rtl/sec_decoder.sv
// Computes the syndrome of a stored codeword, inverts the bit it names,
// and extracts the data byte. Assumes the layout of sec_encoder.
// A nonzero syndrome raises err_o. A syndrome that points past the last
// position (only possible with several flips) raises err_o but flips nothing.
module sec_decoder
    import sec_ram_pkg::*;
(
    input  codeword_t         cw_i,
    output logic [DATA_W-1:0] data_o,
    output logic              err_o
);
    logic [CHK_W-1:0] syn;

    // Syndrome, single-bit repair and data extraction.
    always_comb begin : fix_word
        codeword_t fixed;
        int        j;
        syn = '0;
        for (int c = 0; c < CHK_W; c++) begin
            for (int p = 1; p <= CW_W; p++) begin
                if (p[c]) syn[c] = syn[c] ^ cw_i[p-1];
            end
        end
        fixed = cw_i;
        if (syn != '0 && int'(syn) <= CW_W) begin
            fixed[int'(syn) - 1] = ~fixed[int'(syn) - 1];
        end
        data_o = '0;
        j      = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                data_o[j] = fixed[p-1];
                j++;
            end
        end
    end

    assign err_o = |syn;
endmodule

// File: rtl/sec_mode_decode.sv
// Turns the two selects, the read gate and the write strobe into one mode.
// Deselect overrides everything; the write strobe overrides the read gate.
module sec_mode_decode
    import sec_ram_pkg::*;
(
    input  logic  sel_a_n,
    input  logic  sel_b,
    input  logic  out_en_n,
    input  logic  wr_en_n,
    output mode_t mode_o
);
    // Priority decode of the control truth table.
    always_comb begin : pick_mode
        if (sel_a_n || !sel_b) mode_o = MODE_IDLE;
        else if (!wr_en_n)     mode_o = MODE_WRITE;
        else if (!out_en_n)    mode_o = MODE_READ;
        else                   mode_o = MODE_QUIET;
    end
endmodule

// File: rtl/sec_array.sv
// Register array of codewords with one write port, one XOR-injection
// port and one combinational read port. Assumes a synchronous active-low
// reset that clears every word to the all-zero codeword, which is valid.
// A write and an injection aimed at the same word: the write wins.
module sec_array
    import sec_ram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  codeword_t         wr_cw,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] inj_addr,
    input  codeword_t         inj_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    output codeword_t         rd_cw
);
    localparam int DEPTH = 1 << ADDR_W;

    codeword_t words [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        codeword_t word_q;

        // Update one stored word: reset, write, or fault flip.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                word_q <= wr_cw;
            end else if (inj_en && inj_addr == ADDR_W'(i)) begin
                word_q <= word_q ^ inj_mask;
            end
        end

        assign words[i] = word_q;
    end

    assign rd_cw = words[rd_addr];
endmodule

// File: rtl/sec_byte_ram.sv
// Top of the single-error-correcting byte memory. Writes store an encoded
// byte. A read registers the corrected byte, the repair flag and the
// drive-enables, so they appear one cycle after the command.
// The repair is never written back. Assumes synchronous active-low reset.
module sec_byte_ram
    import sec_ram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              out_en_n,
    input  logic              wr_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drv,
    output logic              fix_flag,
    output logic              fix_flag_drv,
    input  logic              flt_en,
    input  logic [ADDR_W-1:0] flt_addr,
    input  logic [CW_W-1:0]   flt_mask
);
    mode_t             mode;
    codeword_t         enc_cw;
    codeword_t         rd_cw;
    logic [DATA_W-1:0] dec_data;
    logic              dec_err;
    logic              do_write;

    sec_mode_decode u_mode (
        .sel_a_n  (sel_a_n),
        .sel_b    (sel_b),
        .out_en_n (out_en_n),
        .wr_en_n  (wr_en_n),
        .mode_o   (mode)
    );

    sec_encoder u_enc (
        .data_i (wdata),
        .cw_o   (enc_cw)
    );

    assign do_write = (mode == MODE_WRITE);

    sec_array #(.ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (do_write),
        .wr_addr  (addr),
        .wr_cw    (enc_cw),
        .inj_en   (flt_en),
        .inj_addr (flt_addr),
        .inj_mask (flt_mask),
        .rd_addr  (addr),
        .rd_cw    (rd_cw)
    );

    sec_decoder u_dec (
        .cw_i   (rd_cw),
        .data_o (dec_data),
        .err_o  (dec_err)
    );

    // Register the read result; release both pins in every other mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata        <= '0;
            rdata_drv    <= 1'b0;
            fix_flag     <= 1'b0;
            fix_flag_drv <= 1'b0;
        end else if (mode == MODE_READ) begin
            rdata        <= dec_data;
            rdata_drv    <= 1'b1;
            fix_flag     <= dec_err;
            fix_flag_drv <= 1'b1;
        end else begin
            rdata_drv    <= 1'b0;
            fix_flag     <= 1'b0;
            fix_flag_drv <= 1'b0;
        end
    end
endmodule

// File: rtl/sec_byte_ram_chk.sv
// Temporal checks on the drive-enables of sec_byte_ram, bound to every
// instance of it. Assumes the synchronous active-low reset of the top.
module sec_byte_ram_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_a_n,
    input logic sel_b,
    input logic out_en_n,
    input logic wr_en_n,
    input logic rdata_drv,
    input logic fix_flag_drv
);
    assert_deselect_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a_n || !sel_b) |=> (!rdata_drv && !fix_flag_drv));

    assert_read_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_a_n && sel_b && !out_en_n && wr_en_n) |=> rdata_drv);

    assert_write_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_a_n && sel_b && !wr_en_n) |=> (!rdata_drv && !fix_flag_drv));

    assert_flag_follows_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_drv == fix_flag_drv);

    assert_quiet_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_a_n && sel_b && out_en_n && wr_en_n) |=> !rdata_drv);

    assert_reset_release_R10: assert property (@(posedge clk)
        !rst_n |=> (!rdata_drv && !fix_flag_drv));
endmodule

bind sec_byte_ram sec_byte_ram_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_a_n      (sel_a_n),
    .sel_b        (sel_b),
    .out_en_n     (out_en_n),
    .wr_en_n      (wr_en_n),
    .rdata_drv    (rdata_drv),
    .fix_flag_drv (fix_flag_drv)
);

// File: tb/sec_byte_ram_bench.sv
// Scoreboard bench: driver tasks push the expected output of each command
// into a queue, and a monitor pops and compares one item per cycle.
module sec_byte_ram_bench;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int CLK_P = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_a_n = 1'b1, sel_b = 1'b0, out_en_n = 1'b1, wr_en_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          rdata_drv, fix_flag, fix_flag_drv;
    logic          flt_en = 1'b0;
    logic [AW-1:0] flt_addr = '0;
    logic [11:0]   flt_mask = '0;

    sec_byte_ram #(.ADDR_W(AW)) u_sec_byte_ram (
        .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .out_en_n(out_en_n), .wr_en_n(wr_en_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_drv(rdata_drv), .fix_flag(fix_flag),
        .fix_flag_drv(fix_flag_drv), .flt_en(flt_en), .flt_addr(flt_addr),
        .flt_mask(flt_mask)
    );

    always #(CLK_P/2) clk = ~clk;

    logic [9:0]  exp_q [$];   // {drive, flag, byte}
    string       tag_q [$];
    logic [7:0]  m_data [DEPTH];
    logic [11:0] m_flip [DEPTH];
    int          n_chk = 0;
    int          n_fail = 0;

    task automatic put(input logic sa, input logic sb, input logic oe, input logic we,
                       input logic [AW-1:0] a, input logic [7:0] d,
                       input logic fe, input logic [AW-1:0] fa, input logic [11:0] fm);
        @(negedge clk);
        sel_a_n = sa; sel_b = sb; out_en_n = oe; wr_en_n = we;
        addr = a; wdata = d; flt_en = fe; flt_addr = fa; flt_mask = fm;
    endtask

    task automatic push(input logic drv, input logic flg, input logic [7:0] d, input string t);
        exp_q.push_back({drv, flg, d});
        tag_q.push_back(t);
    endtask

    task automatic op_write(input logic [AW-1:0] a, input logic [7:0] d, input logic oe, input string t);
        put(1'b0, 1'b1, oe, 1'b0, a, d, 1'b0, '0, '0);
        m_data[a] = d; m_flip[a] = '0;
        push(1'b0, 1'b0, 8'h00, t);
    endtask

    task automatic op_read(input logic [AW-1:0] a, input string t);
        put(1'b0, 1'b1, 1'b0, 1'b1, a, 8'h00, 1'b0, '0, '0);
        push(1'b1, m_flip[a] != 0, m_data[a], t);
    endtask

    task automatic op_inject(input logic [AW-1:0] a, input logic [11:0] m, input string t);
        put(1'b1, 1'b0, 1'b1, 1'b1, '0, 8'h00, 1'b1, a, m);
        m_flip[a] ^= m;
        push(1'b0, 1'b0, 8'h00, t);
    endtask

    // A command that must neither store nor drive.
    task automatic op_quiet(input logic sa, input logic sb, input logic oe, input logic we,
                            input logic [AW-1:0] a, input logic [7:0] d, input string t);
        put(sa, sb, oe, we, a, d, 1'b0, '0, '0);
        push(1'b0, 1'b0, 8'h00, t);
    endtask

    // Monitor: compare one expected item per cycle, away from the edge.
    initial begin
        forever begin
            logic [9:0] e;
            string      t;
            logic       ok;
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (e[9]) ok = rdata_drv && fix_flag_drv && rdata == e[7:0] && fix_flag == e[8];
                else      ok = !rdata_drv && !fix_flag_drv;
                if (!ok) begin
                    n_fail++;
                    $display("FAIL %s: got drv=%b fdrv=%b data=%h flag=%b, expected drv=%b data=%h flag=%b",
                             t, rdata_drv, fix_flag_drv, rdata, fix_flag, e[9], e[7:0], e[8]);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin m_data[i] = 8'h00; m_flip[i] = '0; end
        repeat (3) @(negedge clk);
        n_chk++;
        if (rdata_drv || fix_flag_drv) begin
            n_fail++;
            $display("FAIL R10 reset: got drv=%b fdrv=%b, expected 0 0", rdata_drv, fix_flag_drv);
        end
        rst_n = 1'b1;

        // R10: every word reads as zero with no repair after reset.
        for (int i = 0; i < DEPTH; i++) op_read(AW'(i), "R10 cleared word");

        // R2, R3: distinct bytes at every address, read back.
        for (int i = 0; i < DEPTH; i++) op_write(AW'(i), 8'(i * 37 + 11), 1'b1, "R2 write");
        for (int i = 0; i < DEPTH; i++) op_read(AW'(i), "R3 read back");

        // R1: writes under each deselect condition are ignored.
        op_quiet(1'b1, 1'b1, 1'b1, 1'b0, 4'd3, 8'hEE, "R1 sel_a high write");
        op_quiet(1'b0, 1'b0, 1'b1, 1'b0, 4'd3, 8'hDD, "R1 sel_b low write");
        op_quiet(1'b1, 1'b0, 1'b0, 1'b1, 4'd3, 8'h00, "R1 deselected read");
        op_read(4'd3, "R1 word unchanged");

        // R4 and R2: write with the read gate low stores and drives nothing.
        op_write(4'd7, 8'h3C, 1'b0, "R4 write with gate low");
        op_read(4'd7, "R2 stored under gate low");
        op_quiet(1'b0, 1'b1, 1'b1, 1'b1, 4'd7, 8'h00, "R4 gate high after read");

        // R8: selected idle mode stores nothing.
        op_quiet(1'b0, 1'b1, 1'b1, 1'b1, 4'd9, 8'hFF, "R8 quiet mode");
        op_read(4'd9, "R8 word unchanged");

        // R5, R9, R7: each single position is repaired, and the damage persists.
        for (int k = 0; k < 12; k++) begin
            op_write(4'd5, 8'hA5 ^ 8'(k), 1'b1, "R9 setup");
            op_inject(4'd5, 12'(1) << k, "R9 inject");
            op_read(4'd5, "R5 repaired read");
            op_read(4'd5, "R7 repeated read still flagged");
        end
        op_write(4'd5, 8'h5A, 1'b1, "R7 rewrite");
        op_read(4'd5, "R7 rewrite clears flag");

        // R9: the same flip twice cancels out.
        op_inject(4'd12, 12'h008, "R9 flip once");
        op_inject(4'd12, 12'h008, "R9 flip again");
        op_read(4'd12, "R9 cancelled flip");

        // R11: the write beats an injection at the same address.
        put(1'b0, 1'b1, 1'b1, 1'b0, 4'd6, 8'h81, 1'b1, 4'd6, 12'h020);
        m_data[6] = 8'h81; m_flip[6] = '0;
        push(1'b0, 1'b0, 8'h00, "R11 write with inject");
        op_read(4'd6, "R11 write wins");

        // R11: a read in the injection cycle sees the old word.
        put(1'b0, 1'b1, 1'b0, 1'b1, 4'd10, 8'h00, 1'b1, 4'd10, 12'h010);
        push(1'b1, 1'b0, m_data[10], "R11 read same cycle as inject");
        m_flip[10] ^= 12'h010;
        op_read(4'd10, "R11 flip visible next read");

        op_quiet(1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 8'h00, "R1 final idle");
        repeat (4) @(posedge clk);
        #3;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule